// File: doc/BRIEF.md
# Latching-Enable Watchdog Timer

This block is a memory-mapped watchdog timer. Software arms it by setting the enable bit in its control word. After that the enable bit stays set until the system is reset. While the watchdog is armed, a whole-second countdown runs from an internal prescaler that divides the core clock down to one tick per second. Any write to the control word restarts the countdown, whatever data the write carries. The reload value is the 4-bit seconds field taken from that same write. If the countdown reaches its end, the block raises a reset request for a fixed number of clock cycles. It then stays idle until the system reset returns it to its starting state.

A reset-cause flag records that a watchdog expiry took place. This flag is cleared only by power-on reset or by software writing a 1 to its bit, so it survives the system reset that the expiry causes. A read-only identification word returns a 16-bit version number. All registers share one address space. Each 32-bit word numbers bit 0 as its least significant bit. Read data appears one clock after the address is presented.

Top module: `sticky_wdt`

## Requirements
- R1: After system reset, the control word (byte offset 0x14) reads 0 and the reset request output `wdt_rst_o` is low.
- R2: Control bit 7 is the enable bit. Once it has been written as 1, later writes of 0 leave it reading 1 and the countdown keeps running.
- R3: Every write to the control word reloads the countdown, whatever the data. With the seconds field (bits 11:8) at 2 and the watchdog armed, a write made before expiry postpones the request to 2 seconds after that write.
- R4: While armed with a seconds field of T, `wdt_rst_o` rises exactly T×TICK_DIV clock cycles after the last control write and stays high for exactly RST_CYC cycles.
- R5: A seconds field of 0 acts as 1 second.
- R6: Rewriting the seconds field while the watchdog runs takes effect from that write. A running 3-second count rewritten to 1 expires 1 second after the rewrite.
- R7: While the enable bit is 0, `wdt_rst_o` never rises.
- R8: After one reset request, the block neither counts nor raises another request until system reset, even when the control word is written again.
- R9: Bit 31 of the cause word (offset 0x40) is set on expiry and survives system reset. Writing 1 to bit 31 clears it, writing 0 leaves it unchanged, and power-on reset clears it.
- R10: The word at offset 0x1C reads VERSION in bits 15:0 and zero above. Writes to it have no effect.
- R11: All control bits other than bit 7 read back as last written. Read data reflects the address presented on the previous clock edge.
- R12: Unmapped offsets read as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| por_n | input | 1 | Power-on reset, active low, clears everything including the cause flag |
| rst_n | input | 1 | System reset, active low, clears everything except the cause flag |
| bus_addr | input | ADDR_W | Byte offset of the register access |
| bus_we | input | 1 | Write strobe, one write per cycle in which it is high |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the address presented on the previous edge |
| wdt_rst_o | output | 1 | Reset request, high for RST_CYC cycles on expiry |

## Verification
The assertions check on every cycle that the request pulse has the exact RST_CYC width and that the enable bit never drops. They also check that no request appears while the watchdog is disarmed or right after a kick, that the block stays silent after it has fired, and that the cause flag is set whenever a request starts. Only the bench scenarios can show the absolute expiry time in seconds, the reload from a rewritten seconds field, the handling of a zero field, and the register contents as read over the bus. The same holds for the cause flag's behaviour across system and power-on resets.

// File: rtl/sticky_wdt_pkg.sv
package sticky_wdt_pkg;
  localparam int WORD_W   = 32;
  localparam int SEC_W    = 4;
  localparam int EN_BIT   = 7;
  localparam int SEC_LSB  = 8;
  localparam int CAUSE_BIT = 31;
  localparam logic [7:0] OFS_CTRL  = 8'h14;
  localparam logic [7:0] OFS_VER   = 8'h1C;
  localparam logic [7:0] OFS_CAUSE = 8'h40;

  typedef logic [SEC_W-1:0] sec_t;

  // a zero seconds field behaves as one second
  function automatic sec_t eff_sec(input sec_t raw);
    return (raw == '0) ? sec_t'(1) : raw;
  endfunction
endpackage

// File: rtl/sticky_wdt_prescale.sv
module sticky_wdt_prescale #(
  parameter int TICK_DIV = 50_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic clear,
  output logic tick
);
  localparam int PW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(TICK_DIV - 1);

  logic [PW-1:0] pre_q;

  assign tick = run && !clear && (pre_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  pre_q <= '0;
    else if (clear || !run)      pre_q <= '0;
    else if (pre_q == LAST)      pre_q <= '0;
    else                         pre_q <= pre_q + 1'b1;
  end
endmodule

// File: rtl/sticky_wdt_core.sv
module sticky_wdt_core
  import sticky_wdt_pkg::*;
#(
  parameter int RST_CYC = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic armed,
  input  logic kick,
  input  sec_t load_sec,
  input  logic tick,
  output logic fired,
  output logic fire,
  output logic rst_req
);
  localparam int PCW = $clog2(RST_CYC + 1);

  sec_t           cnt_q;
  logic           fired_q;
  logic [PCW-1:0] pulse_q;

  assign fire    = !fired_q && !kick && armed && tick && (cnt_q <= sec_t'(1));
  assign fired   = fired_q;
  assign rst_req = (pulse_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      fired_q <= 1'b0;
      pulse_q <= '0;
    end else if (fired_q) begin
      if (pulse_q != '0) pulse_q <= pulse_q - 1'b1;
    end else if (kick) begin
      cnt_q <= load_sec;
    end else if (fire) begin
      fired_q <= 1'b1;
      pulse_q <= PCW'(RST_CYC);
    end else if (armed && tick) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/sticky_wdt_regs.sv
module sticky_wdt_regs
  import sticky_wdt_pkg::*;
#(
  parameter int              ADDR_W  = 8,
  parameter logic [15:0]     VERSION = 16'h0107
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              we,
  input  logic [WORD_W-1:0] wdata,
  input  logic              fire,
  output logic [WORD_W-1:0] rdata,
  output logic [WORD_W-1:0] ctrl,
  output logic              cause,
  output logic              kick,
  output sec_t              load_sec
);
  localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(OFS_CTRL);
  localparam logic [ADDR_W-1:0] A_VER   = ADDR_W'(OFS_VER);
  localparam logic [ADDR_W-1:0] A_CAUSE = ADDR_W'(OFS_CAUSE);
  localparam logic [WORD_W-1:0] EN_MASK = WORD_W'(1) << EN_BIT;

  logic [WORD_W-1:0] ctrl_q;
  logic [WORD_W-1:0] rdata_q;
  logic              cause_q;

  assign kick     = we && (addr == A_CTRL);
  assign load_sec = eff_sec(wdata[SEC_LSB +: SEC_W]);
  assign ctrl     = ctrl_q;
  assign cause    = cause_q;
  assign rdata    = rdata_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ctrl_q <= '0;
    else if (kick)  ctrl_q <= wdata | (ctrl_q & EN_MASK);
  end

  // cause flag lives on the power-on domain only
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)                                          cause_q <= 1'b0;
    else if (fire)                                       cause_q <= 1'b1;
    else if (we && (addr == A_CAUSE) && wdata[CAUSE_BIT]) cause_q <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata_q <= '0;
    else begin
      unique case (addr)
        A_CTRL:  rdata_q <= ctrl_q;
        A_VER:   rdata_q <= {16'h0000, VERSION};
        A_CAUSE: rdata_q <= {cause_q, {(WORD_W-1){1'b0}}};
        default: rdata_q <= '0;
      endcase
    end
  end
endmodule

// File: rtl/sticky_wdt.sv
module sticky_wdt
  import sticky_wdt_pkg::*;
#(
  parameter int          ADDR_W   = 8,
  parameter int          TICK_DIV = 50_000_000,
  parameter int          RST_CYC  = 16,
  parameter logic [15:0] VERSION  = 16'h0107
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              wdt_rst_o
);
  logic [WORD_W-1:0] ctrl;
  logic              cause;
  logic              kick;
  sec_t              load_sec;
  logic              tick;
  logic              fired;
  logic              fire;
  logic              armed;

  assign armed = ctrl[EN_BIT];

  sticky_wdt_regs #(.ADDR_W(ADDR_W), .VERSION(VERSION)) u_regs (
    .clk(clk), .por_n(por_n), .rst_n(rst_n),
    .addr(bus_addr), .we(bus_we), .wdata(bus_wdata), .fire(fire),
    .rdata(bus_rdata), .ctrl(ctrl), .cause(cause), .kick(kick),
    .load_sec(load_sec)
  );

  sticky_wdt_prescale #(.TICK_DIV(TICK_DIV)) u_pre (
    .clk(clk), .rst_n(rst_n), .run(armed && !fired), .clear(kick),
    .tick(tick)
  );

  sticky_wdt_core #(.RST_CYC(RST_CYC)) u_core (
    .clk(clk), .rst_n(rst_n), .armed(armed), .kick(kick),
    .load_sec(load_sec), .tick(tick), .fired(fired), .fire(fire),
    .rst_req(wdt_rst_o)
  );
endmodule

// File: rtl/sticky_wdt_chk.sv
module sticky_wdt_chk #(
  parameter int ADDR_W  = 8,
  parameter int RST_CYC = 16
) (
  input logic              clk,
  input logic              por_n,
  input logic              rst_n,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              wdt_rst_o,
  input logic              armed,
  input logic              fired,
  input logic              cause
);
  localparam int HW = $clog2(RST_CYC + 1) + 1;
  logic [HW-1:0] hi_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         hi_cnt <= '0;
    else if (wdt_rst_o) hi_cnt <= hi_cnt + 1'b1;
    else                hi_cnt <= '0;
  end

  a_r4_pulse_max: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    wdt_rst_o |-> (hi_cnt < HW'(RST_CYC)));

  a_r4_pulse_min: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    $fell(wdt_rst_o) |-> (hi_cnt == HW'(RST_CYC)));

  a_r2_enable_holds: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    armed |=> armed);

  a_r7_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    !armed |-> !wdt_rst_o);

  a_r3_kick_defers: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    (bus_we && bus_addr == ADDR_W'(8'h14) && !fired) |=> !wdt_rst_o);

  a_r8_one_shot: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    (fired && !wdt_rst_o) |=> !wdt_rst_o);

  a_r9_cause_set: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    $rose(wdt_rst_o) |-> cause);
endmodule

bind sticky_wdt sticky_wdt_chk #(.ADDR_W(ADDR_W), .RST_CYC(RST_CYC)) u_chk (
  .clk(clk), .por_n(por_n), .rst_n(rst_n), .bus_we(bus_we),
  .bus_addr(bus_addr), .wdt_rst_o(wdt_rst_o), .armed(armed),
  .fired(fired), .cause(cause)
);

// File: tb/sticky_wdt_tb.sv
module sticky_wdt_tb;
  localparam int DIV = 20;
  localparam int RC  = 4;
  localparam logic [15:0] VER = 16'hA5C3;

  logic        clk = 1'b0;
  logic        por_n = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = 8'h00;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        wdt_rst_o;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #10 clk = ~clk;

  sticky_wdt #(.ADDR_W(8), .TICK_DIV(DIV), .RST_CYC(RC), .VERSION(VER)) u_dut (
    .clk(clk), .por_n(por_n), .rst_n(rst_n), .bus_addr(bus_addr),
    .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .wdt_rst_o(wdt_rst_o)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic sys_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // after wr returns at N0: stay low through N(k-1) then high at Nk
  task automatic expect_fire(input int k, input string req);
    bit early = 0;
    for (int i = 1; i < k; i++) begin
      @(negedge clk);
      if (wdt_rst_o) early = 1;
    end
    chk(!early, req, 32'(early), 0);
    @(negedge clk);
    chk(wdt_rst_o == 1'b1, req, 32'(wdt_rst_o), 1);
  endtask

  task automatic quiet(input int n, input string req);
    bit seen = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (wdt_rst_o) seen = 1;
    end
    chk(!seen, req, 32'(seen), 0);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    chk(wdt_rst_o == 1'b0, "R1", 32'(wdt_rst_o), 0);
    rd(8'h14, v); chk(v == 0, "R1", v, 0);
    rd(8'h40, v); chk(v == 0, "R9", v, 0);
  endtask

  task automatic t_regs();
    logic [31:0] v;
    wr(8'h14, 32'hF0F0_F05A);
    rd(8'h14, v); chk(v == 32'hF0F0_F05A, "R11", v, 32'hF0F0_F05A);
    rd(8'h1C, v); chk(v == {16'h0, VER}, "R10", v, {16'h0, VER});
    wr(8'h1C, 32'hFFFF_FFFF);
    rd(8'h1C, v); chk(v == {16'h0, VER}, "R10", v, {16'h0, VER});
    rd(8'h00, v); chk(v == 0, "R12", v, 0);
    rd(8'h44, v); chk(v == 0, "R12", v, 0);
    quiet(5 * DIV, "R7");
    sys_reset();
  endtask

  task automatic t_expire();
    logic [31:0] v;
    bit pulse_ok = 1;
    wr(8'h14, 32'h0000_0280);
    expect_fire(2 * DIV, "R4");
    for (int i = 1; i < RC; i++) begin
      @(negedge clk);
      if (!wdt_rst_o) pulse_ok = 0;
    end
    chk(pulse_ok, "R4", 32'(pulse_ok), 1);
    @(negedge clk);
    chk(wdt_rst_o == 1'b0, "R4", 32'(wdt_rst_o), 0);
    rd(8'h40, v); chk(v == 32'h8000_0000, "R9", v, 32'h8000_0000);
    wr(8'h14, 32'h0000_0180);
    quiet(4 * DIV, "R8");
    sys_reset();
    rd(8'h14, v); chk(v == 0, "R1", v, 0);
    rd(8'h40, v); chk(v == 32'h8000_0000, "R9", v, 32'h8000_0000);
    wr(8'h40, 32'h7FFF_FFFF);
    rd(8'h40, v); chk(v == 32'h8000_0000, "R9", v, 32'h8000_0000);
    wr(8'h40, 32'h8000_0000);
    rd(8'h40, v); chk(v == 0, "R9", v, 0);
  endtask

  task automatic t_sticky_zero();
    logic [31:0] v;
    sys_reset();
    wr(8'h14, 32'h0000_0280);
    wr(8'h14, 32'h0000_0000);
    expect_fire(DIV, "R5");
    rd(8'h14, v); chk(v == 32'h0000_0080, "R2", v, 32'h80);
    sys_reset();
  endtask

  task automatic t_kick();
    wr(8'h14, 32'h0000_0280);
    quiet(30, "R3");
    wr(8'h14, 32'h0000_0200);
    expect_fire(2 * DIV, "R3");
    sys_reset();
  endtask

  task automatic t_retime();
    wr(8'h14, 32'h0000_0380);
    quiet(10, "R6");
    wr(8'h14, 32'h0000_0180);
    expect_fire(DIV, "R6");
    sys_reset();
  endtask

  task automatic t_por();
    logic [31:0] v;
    rd(8'h40, v); chk(v == 32'h8000_0000, "R9", v, 32'h8000_0000);
    @(negedge clk); por_n = 1'b0; rst_n = 1'b0;
    repeat (2) @(negedge clk);
    por_n = 1'b1; rst_n = 1'b1;
    rd(8'h40, v); chk(v == 0, "R9", v, 0);
  endtask

  initial begin
    fork
      begin
        repeat (20000) @(negedge clk);
        if (!done) begin
          total++; bad++;
          $display("FAIL watchdog actual=hung expected=finish");
          $display("  test done: total=%0d bad=%0d", total, bad);
          $finish;
        end
      end
    join_none
    repeat (3) @(negedge clk);
    por_n = 1'b1; rst_n = 1'b1;
    t_reset();
    t_regs();
    t_expire();
    t_sticky_zero();
    t_kick();
    t_retime();
    t_por();
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule